// File: doc/BRIEF.md
# Key-Gated EEPROM Erase Controller

This block sits on a simple register port and launches erase operations on a data EEPROM array. Software first loads a target word address and a control word. The control word holds an operation code and a write-enable bit. Software then writes two key bytes to a key register and, as the very next bus write, sets the start bit of the control register. A start request that does not directly follow the two keys is dropped. So is a request made without the write-enable bit or with an unknown operation code.

An accepted start runs a timed erase. Its length in cycles comes from the clock frequency and the erase time. The bus stays fully usable while the erase runs, but writes to the address and control registers are ignored until it finishes. At the end, the controller pulses an erase strobe with the address and the word/block choice. The strobe goes to an internal behavioural array model. In the same cycle the controller clears the start bit and sets a sticky completion flag, which also drives the interrupt output. Erased words read back as 0xFFFF through a plain array read port.

The register port has no data stream and no back-pressure. Every write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `ee_erase_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000, `busy`, `erase_irq` and `erase_stb` are 0, and array word i reads 0xA500 | i.
- R2: The register selects on `bus_addr` are 0 = control, 1 = address, 2 = key and 3 = flag. A key write with low byte 0x55, followed by a key write with low byte 0xAA, followed by a control write with bit 15 (start) and bit 14 (write enable) set and bits 6:0 equal to 0x44 or 0x45, starts an erase. `busy` and control bit 15 read 1 from the next cycle.
- R3: A start bit set without that exact pair of keys directly before it starts nothing. This covers keys in the wrong order, a repeated 0x55, and any other bus write between or after the keys. Control bit 15 stays 0 and the array is unchanged.
- R4: A start request with bit 14 clear, or with an operation code other than 0x44 or 0x45, starts nothing.
- R5: An accepted erase keeps `busy` high for exactly ERASE_CYCLES = (CLK_HZ/1000000)*ERASE_US cycles. Control bit 15 clears at the edge where `busy` falls.
- R6: While `busy` is high, writes to the address and control registers are ignored, and every register stays readable.
- R7: Operation code 0x44 erases only the addressed word to 0xFFFF.
- R8: Operation code 0x45 erases to 0xFFFF every word of the BLOCK_WORDS-aligned block that holds the address. All other words stay unchanged.
- R9: The flag register bit 0 and `erase_irq` become 1 when an erase ends. They stay 1 when bit 0 is written as 1, and clear only when bit 0 is written as 0.
- R10: `erase_stb` is high for exactly one cycle per erase, in the last busy cycle, with `erase_addr` equal to the address register and `erase_blk` equal to 1 for a block erase.
- R11: Each unlock allows one start attempt only. After an erase, or after a rejected start, a new start needs a fresh key pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| busy | output | 1 | Erase in progress |
| erase_irq | output | 1 | Sticky erase-complete flag |
| erase_stb | output | 1 | One-cycle erase command to the array |
| erase_blk | output | 1 | 1 = block erase, 0 = word erase |
| erase_addr | output | AW | Erase word address |
| mem_raddr | input | AW | Array read address |
| mem_rdata | output | 16 | Array read data |

## Verification
A sequencer stuck in its armed state would show up at the next start request. That request would raise `busy` and set control bit 15 one cycle later, even though it was never unlocked. A sequencer stuck unarmed would show up the same way: a correctly unlocked start would leave `busy` low. A wrong timer count shows as a busy window longer or shorter than ERASE_CYCLES, measured to the cycle. A wrong block mask or address latch shows in the array read-back only after the strobe, so the whole array is compared after every request. Lost flag state appears on `erase_irq` in the cycle after the strobe.

// File: rtl/ee_erase_pkg.sv
package ee_erase_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_KEY  = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam logic [7:0]  KEY_FIRST  = 8'h55;
  localparam logic [7:0]  KEY_SECOND = 8'hAA;
  localparam logic [6:0]  OP_WORD    = 7'h44;
  localparam logic [6:0]  OP_BLOCK   = 7'h45;
  localparam int          START_BIT  = 15;
  localparam int          WREN_BIT   = 14;
  localparam int          DATA_W     = 16;
  localparam logic [15:0] INIT_BASE  = 16'hA500;
endpackage

// File: rtl/ee_unlock_seq.sv
module ee_unlock_seq
  import ee_erase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [7:0]        key_byte,
  output logic              armed
);
  unlock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr) begin
      if (sel == SEL_KEY) begin
        if (key_byte == KEY_FIRST)
          state_d = UL_HALF;
        else if (state_q == UL_HALF && key_byte == KEY_SECOND)
          state_d = UL_ARMED;
        else
          state_d = UL_IDLE;
      end else begin
        state_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/ee_erase_timer.sv
module ee_erase_timer #(
  parameter int CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/ee_array_model.sv
module ee_array_model
  import ee_erase_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int BLOCK_WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     erase_stb,
  input  logic                     erase_blk,
  input  logic [$clog2(DEPTH)-1:0] erase_addr,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = erase_stb &&
                 (erase_blk ? ((i / BLOCK_WORDS) == (int'(erase_addr) / BLOCK_WORDS))
                            : (int'(erase_addr) == i));
    always_ff @(posedge clk) begin
      if (!rst_n)   mem_q[i] <= INIT_BASE | DATA_W'(i);
      else if (hit) mem_q[i] <= '1;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ee_erase_ctrl.sv
module ee_erase_ctrl
  import ee_erase_pkg::*;
#(
  parameter int CLK_HZ      = 100000000,
  parameter int ERASE_US    = 2000,
  parameter int DEPTH       = 64,
  parameter int BLOCK_WORDS = 16,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          busy,
  output logic          erase_irq,
  output logic          erase_stb,
  output logic          erase_blk,
  output logic [AW-1:0] erase_addr,
  input  logic [AW-1:0] mem_raddr,
  output logic [15:0]   mem_rdata
);
  localparam int ERASE_CYCLES = (CLK_HZ / 1000000) * ERASE_US;

  reg_sel_e      sel;
  logic          armed;
  logic          op_ok;
  logic          accept;
  logic          done;
  logic [14:0]   ctrl_q;
  logic          start_q;
  logic [AW-1:0] addr_q;
  logic          flag_q;

  assign sel    = reg_sel_e'(bus_addr);
  assign op_ok  = (bus_wdata[6:0] == OP_WORD) || (bus_wdata[6:0] == OP_BLOCK);
  assign accept = bus_wr && (sel == SEL_CTRL) && armed && !busy &&
                  bus_wdata[START_BIT] && bus_wdata[WREN_BIT] && op_ok;

  ee_unlock_seq u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .sel      (sel),
    .key_byte (bus_wdata[7:0]),
    .armed    (armed)
  );

  ee_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
      addr_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (bus_wr && !busy && sel == SEL_CTRL) ctrl_q <= bus_wdata[14:0];
      if (bus_wr && !busy && sel == SEL_ADDR) addr_q <= bus_wdata[AW-1:0];
      if (accept)     start_q <= 1'b1;
      else if (done)  start_q <= 1'b0;
      if (done)       flag_q <= 1'b1;
      else if (bus_wr && sel == SEL_FLAG && !bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = {start_q, ctrl_q};
      SEL_ADDR: bus_rdata = 16'(addr_q);
      SEL_KEY:  bus_rdata = 16'h0000;
      SEL_FLAG: bus_rdata = {15'd0, flag_q};
      default:  bus_rdata = 16'h0000;
    endcase
  end

  assign erase_irq  = flag_q;
  assign erase_stb  = done;
  assign erase_blk  = (ctrl_q[6:0] == OP_BLOCK);
  assign erase_addr = addr_q;

  ee_array_model #(.DEPTH(DEPTH), .BLOCK_WORDS(BLOCK_WORDS)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_stb  (erase_stb),
    .erase_blk  (erase_blk),
    .erase_addr (erase_addr),
    .raddr      (mem_raddr),
    .rdata      (mem_rdata)
  );
endmodule

// File: rtl/ee_erase_ctrl_chk.sv
module ee_erase_ctrl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [15:0]   bus_wdata,
  input logic          busy,
  input logic          erase_stb,
  input logic [AW-1:0] erase_addr,
  input logic          erase_irq,
  input logic          armed
);
  assert_stb_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> !erase_stb);

  assert_stb_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |-> busy);

  assert_busy_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> !busy);

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> erase_irq);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_irq && !(bus_wr && bus_addr == 2'd3 && !bus_wdata[0])) |=> erase_irq);

  assert_start_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_addr == 2'd0 && bus_wdata[15] && bus_wdata[14]));

  assert_start_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(erase_addr));
endmodule

bind ee_erase_ctrl ee_erase_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .erase_stb  (erase_stb),
  .erase_addr (erase_addr),
  .erase_irq  (erase_irq),
  .armed      (armed)
);

// File: tb/ee_erase_ctrl_tb_top.sv
`timescale 1ns/1ps
module ee_erase_ctrl_tb_top;
  localparam int CLK_HZ = 1000000;
  localparam int EUS    = 20;
  localparam int NCYC   = 20;
  localparam int DEPTH  = 64;
  localparam int BLK    = 16;
  localparam int AW     = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [15:0]   bus_wdata = 16'd0;
  logic [15:0]   bus_rdata;
  logic          busy, erase_irq, erase_stb, erase_blk;
  logic [AW-1:0] erase_addr;
  logic [AW-1:0] mem_raddr = '0;
  logic [15:0]   mem_rdata;

  int   n_total = 0;
  int   n_fail  = 0;
  bit   ended   = 0;
  logic [15:0] exp_mem [DEPTH];

  always #5 clk = ~clk;

  ee_erase_ctrl #(.CLK_HZ(CLK_HZ), .ERASE_US(EUS), .DEPTH(DEPTH), .BLOCK_WORDS(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .erase_irq(erase_irq), .erase_stb(erase_stb), .erase_blk(erase_blk),
    .erase_addr(erase_addr), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata));

  // k1, k2, intervening write, control value, address, start expected
  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {8'h55, 8'hAA, 1'b0, 16'hC044, 6'd5,  1'b1},
    {8'hAA, 8'h55, 1'b0, 16'hC044, 6'd9,  1'b0},
    {8'h55, 8'hAA, 1'b1, 16'hC045, 6'd20, 1'b0},
    {8'h55, 8'hAA, 1'b0, 16'h8044, 6'd9,  1'b0},
    {8'h55, 8'hAA, 1'b0, 16'hC046, 6'd9,  1'b0},
    {8'h55, 8'h55, 1'b0, 16'hC044, 6'd9,  1'b0},
    {8'h55, 8'hAA, 1'b0, 16'hC045, 6'd37, 1'b1},
    {8'h55, 8'hAA, 1'b0, 16'hC044, 6'd63, 1'b1},
    {8'h55, 8'hAA, 1'b0, 16'hC045, 6'd2,  1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(2'd2, 16'h0055);
    wr(2'd2, 16'h00AA);
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    int first_i = 0;
    logic [15:0] fa = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mem_raddr = AW'(i);
      #1;
      if (mem_rdata !== exp_mem[i]) begin
        if (bad == 0) begin first_i = i; fa = mem_rdata; end
        bad++;
      end
    end
    chk(bad == 0, tag, fa, exp_mem[first_i]);
  endtask

  task automatic wait_done(output int cyc, output int stbs,
                           output logic [AW-1:0] sa, output logic sb);
    cyc = 0; stbs = 0; sa = '0; sb = 1'b0;
    while (busy && cyc < 1000) begin
      if (erase_stb) begin stbs++; sa = erase_addr; sb = erase_blk; end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic model_erase(input logic [AW-1:0] a, input bit blk);
    for (int i = 0; i < DEPTH; i++)
      if (blk ? (i / BLK == int'(a) / BLK) : (i == int'(a))) exp_mem[i] = 16'hFFFF;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r;
    int cyc, stbs;
    logic [AW-1:0] sa;
    logic sb;

    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hA500 | 16'(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    begin
      int bad = 0;
      for (int k = 0; k < 4; k++) begin rd(2'(k), r); if (r != 16'd0) bad++; end
      chk(bad == 0, "R1 registers zero after reset", bad, 0);
    end
    chk(!busy && !erase_irq && !erase_stb, "R1 status low after reset",
        {busy, erase_irq, erase_stb}, 0);
    check_mem("R1 array initial contents");

    // vector table: R2 R3 R4 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  k1, k2;
      logic        mid, expst;
      logic [15:0] cv;
      logic [AW-1:0] av;
      string tag;
      {k1, k2, mid, cv, av, expst} = VEC[v];
      tag = expst ? ((cv[6:0] == 7'h45) ? "R8 block erase" : "R7 word erase")
                  : "R3 R4 rejected start";
      wr(2'd3, 16'h0000);
      wr(2'd1, 16'(av));
      wr(2'd0, cv & 16'h7FFF);
      wr(2'd2, {8'h00, k1});
      if (mid) wr(2'd1, 16'(av));
      wr(2'd2, {8'h00, k2});
      wr(2'd0, cv | 16'h8000);
      chk(busy == expst, {"R2 busy after start: ", tag}, busy, expst);
      rd(2'd0, r);
      chk(r[15] == expst, {"R2 start bit: ", tag}, r[15], expst);
      if (expst) begin
        wait_done(cyc, stbs, sa, sb);
        chk(cyc == NCYC, "R5 busy length", cyc, NCYC);
        chk(stbs == 1 && sa == av && sb == (cv[6:0] == 7'h45),
            "R10 strobe count/addr/blk", {stbs[7:0], 2'(sb), 8'(sa)},
            {8'd1, 2'(cv[6:0] == 7'h45), 8'(av)});
        rd(2'd3, r);
        chk(r == 16'd1 && erase_irq, "R9 flag set at end", r, 1);
        model_erase(av, cv[6:0] == 7'h45);
      end else begin
        stbs = 0;
        for (int c = 0; c < NCYC + 5; c++) begin
          if (erase_stb || busy) stbs++;
          @(negedge clk);
        end
        chk(stbs == 0, {"R3 no activity: ", tag}, stbs, 0);
      end
      check_mem({"array after: ", tag});
    end

    // R11 second start without new keys
    wr(2'd1, 16'd12);
    wr(2'd0, 16'hC044);
    chk(!busy, "R11 start after erase without keys", busy, 0);
    unlock();
    wr(2'd0, 16'h4044);
    wr(2'd0, 16'hC044);
    chk(!busy, "R11 start after consumed unlock", busy, 0);
    repeat (NCYC + 2) @(negedge clk);
    check_mem("R11 array unchanged");

    // R6 writes ignored during erase, R5 start bit clears
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'd50);
    unlock();
    wr(2'd0, 16'hC044);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0000);
    rd(2'd1, r);
    chk(r == 16'd50, "R6 address write ignored while busy", r, 50);
    rd(2'd0, r);
    chk(r == 16'hC044, "R6 control write ignored while busy", r, 16'hC044);
    rd(2'd3, r);
    chk(r == 16'd0 && busy, "R6 flag readable while busy", r, 0);
    wait_done(cyc, stbs, sa, sb);
    chk(cyc == NCYC - 4, "R5 remaining busy length", cyc, NCYC - 4);
    rd(2'd0, r);
    chk(r == 16'h4044, "R5 start bit cleared at end", r, 16'h4044);
    model_erase(6'd50, 1'b0);
    check_mem("R6 R7 word at latched address");

    // R9 flag write semantics
    wr(2'd3, 16'h0001);
    chk(erase_irq, "R9 flag holds on write of one", erase_irq, 1);
    wr(2'd3, 16'h0000);
    rd(2'd3, r);
    chk(r == 16'd0 && !erase_irq, "R9 flag cleared by write of zero", r, 0);

    summary();
    $finish;
  end
endmodule